// File: doc/BRIEF.md
# Selectable CRC Accumulator on an SPI Bit Tap

This block keeps a running cyclic redundancy check over the bits that move through a serial peripheral shifter. The shifter is outside the block. It reports each bit on a tap made of three signals: the bit value, a valid strobe, and a flag that tells whether the bit was sent or received. Firmware uses the accumulated value in one of two ways. It can append the value to an outgoing frame, or it can compare the value against a checksum that arrived with incoming data.

A small register port gives access to one control register and one result register. In the control register, software picks a 7-bit or a 16-bit polynomial and picks which traffic direction feeds the engine. It can also freeze the accumulator. Freezing matters when the checksum itself is shifted out, because those bits must not change a value that firmware still needs. Clearing the accumulator takes two writes to one control bit: a write of 0 and then a write of 1. A lone write of 1 does nothing.

The register port uses a word-wide write strobe and a combinational read path. A mode change leaves the accumulator as it is, so software runs the clear sequence again after switching polynomials.

Top module: `crc_tap_engine`

## Requirements
- R1: After reset the result register (address 1) reads 0x0000 and the control register (address 0) reads 0x0004.
- R2: When the mode bit (control bit 0) is 1, each accepted bit updates a 16-bit value with polynomial 0x1021. The update is most significant bit first and starts from zero. The ASCII bytes "123456789" give 0x31C3.
- R3: When the mode bit is 0, the polynomial is 0x09, a 7-bit value. The result sits in bits 6:0 and bits 15:7 read zero. The ASCII bytes "123456789" give 0x75.
- R4: When the direction bit (control bit 1) is 0, only tap bits whose direction flag is 0 (transmit) update the value. Bits flagged 1 leave it unchanged.
- R5: When the direction bit is 1, only tap bits whose direction flag is 1 (receive) update the value. Bits flagged 0 leave it unchanged.
- R6: The value clears only on a control write that carries 1 in bit 2 while the stored bit 2 is 0. Writing 1 over a stored 1 does not clear it, and neither does writing 0.
- R7: While the freeze bit (control bit 3) is 1, the value does not change.
- R8: Changing the mode bit does not clear the value. In the 7-bit mode, the update continues from the low seven bits.
- R9: A cycle in which the valid strobe is low leaves the value unchanged, whatever the bit and flag inputs are.
- R10: The control register reads back the last written bits 3:0 and reads zero above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 result) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| tap_bit | input | 1 | Bit value from the shifter |
| tap_valid | input | 1 | Bit strobe, one bit per cycle while high |
| tap_dir | input | 1 | 0 for a sent bit, 1 for a received bit |

## Verification
The bench first feeds the standard nine-byte check string in both modes. A wrong polynomial, a wrong shift direction or a wrong lane width each produce a different known check value. Random byte streams in both modes and both directions are then compared against a bitwise model, with bits from the opposite direction interleaved between them. These streams show whether the direction filter holds on every bit and not only on whole bytes. Further sequences vary the write history on the clear bit, freeze the value mid-stream, switch modes with data already accumulated, and toggle the tap inputs while the strobe is low. Each of these separates clear, hold and continue behaviour that plain streams cannot distinguish.

// File: rtl/crc_tap_pkg.sv
package crc_tap_pkg;
   // register addresses
   localparam int CTRL_ADDR = 0;
   localparam int RES_ADDR  = 1;
   // control field positions (the bench and firmware decode these)
   localparam int MODE_POS = 0;
   localparam int DIR_POS  = 1;
   localparam int CLR_POS  = 2;
   localparam int FRZ_POS  = 3;
   localparam int CTRL_W   = 4;

   typedef struct packed {
      logic frz;     // bit 3
      logic clr;     // bit 2
      logic dir_rx;  // bit 1
      logic mode16;  // bit 0
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{frz: 1'b0, clr: 1'b1, dir_rx: 1'b0, mode16: 1'b0};
endpackage

// File: rtl/crc_ctrl_regs.sv
module crc_ctrl_regs
   import crc_tap_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output ctrl_t             ctrl,
   output logic              clr_pulse
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   generate
      if (DATA_W < CTRL_W) begin : g_bad_width
         $error("crc_ctrl_regs: DATA_W too small for control fields");
      end
   endgenerate

   logic  wr_ctrl;
   ctrl_t ctrl_q;
   logic  unused_hi;

   assign wr_ctrl   = wr_en && (wr_addr == CTRL_A);
   assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];
   // clear fires only on the 0 -> 1 step of the stored reset bit
   assign clr_pulse = wr_ctrl && wr_data[CLR_POS] && !ctrl_q.clr;
   assign ctrl      = ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= CTRL_RST;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   // R6: after a clear the stored bit is 1, so a repeat write of 1 cannot clear again
   assert_clr_leaves_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> ctrl_q.clr);
   // R10: a control write lands in the register
   assert_ctrl_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == ctrl_t'($past(wr_data[CTRL_W-1:0])));
   // R10: without a write the control bits hold
   assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
   parameter int           W    = 16,
   parameter logic [W-1:0] POLY = '0
) (
   input  logic [W-1:0] cur,
   input  logic         bit_in,
   output logic [W-1:0] nxt
);
   generate
      if (W < 2) begin : g_bad_w
         $error("crc_lfsr_step: W must be at least 2");
      end
   endgenerate

   logic fb;
   assign fb  = bit_in ^ cur[W-1];
   assign nxt = {cur[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
   parameter int                  WIDE_W      = 16,
   parameter int                  NARROW_W    = 7,
   parameter logic [WIDE_W-1:0]   WIDE_POLY   = 16'h1021,
   parameter logic [NARROW_W-1:0] NARROW_POLY = 7'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_en,
   input  logic              mode16,
   input  logic              bit_in,
   output logic [WIDE_W-1:0] acc
);
   generate
      if (NARROW_W >= WIDE_W) begin : g_bad_lanes
         $error("crc_accum: narrow lane must be smaller than wide lane");
      end
   endgenerate

   logic [WIDE_W-1:0]   acc_q, acc_d, nxt_wide;
   logic [NARROW_W-1:0] nxt_narrow;

   crc_lfsr_step #(.W(WIDE_W), .POLY(WIDE_POLY)) u_wide (
      .cur(acc_q), .bit_in(bit_in), .nxt(nxt_wide));

   crc_lfsr_step #(.W(NARROW_W), .POLY(NARROW_POLY)) u_narrow (
      .cur(acc_q[NARROW_W-1:0]), .bit_in(bit_in), .nxt(nxt_narrow));

   always_comb begin
      acc_d = acc_q;
      if (clr)          acc_d = '0;
      else if (step_en) acc_d = mode16 ? nxt_wide : WIDE_W'(nxt_narrow);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   assign acc = acc_q;

   // R6: a clear strobe empties the value
   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> acc_q == '0);
   // R9: no accepted bit and no clear means the value holds
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step_en) |=> $stable(acc_q));
   // R3: a narrow-mode step keeps the upper bits empty
   assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && step_en && !mode16) |=> acc_q[WIDE_W-1:NARROW_W] == '0);
endmodule

// File: rtl/crc_tap_engine.sv
module crc_tap_engine
   import crc_tap_pkg::*;
#(
   parameter int                  ADDR_W      = 2,
   parameter int                  DATA_W      = 16,
   parameter int                  WIDE_W      = 16,
   parameter int                  NARROW_W    = 7,
   parameter logic [WIDE_W-1:0]   WIDE_POLY   = 16'h1021,
   parameter logic [NARROW_W-1:0] NARROW_POLY = 7'h09
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tap_bit,
   input  logic              tap_valid,
   input  logic              tap_dir
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] RES_A  = ADDR_W'(RES_ADDR);

   generate
      if (DATA_W < WIDE_W) begin : g_bad_data
         $error("crc_tap_engine: DATA_W must hold the wide result");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("crc_tap_engine: ADDR_W must be at least 1");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              clr_pulse, step_en;
   logic [WIDE_W-1:0] acc;
   logic [DATA_W-1:0] res_view;

   crc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl(ctrl), .clr_pulse(clr_pulse));

   assign step_en = tap_valid && (tap_dir == ctrl.dir_rx) && !ctrl.frz;

   crc_accum #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
               .WIDE_POLY(WIDE_POLY), .NARROW_POLY(NARROW_POLY)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .step_en(step_en),
      .mode16(ctrl.mode16), .bit_in(tap_bit), .acc(acc));

   assign res_view = ctrl.mode16 ? DATA_W'(acc) : DATA_W'(acc[NARROW_W-1:0]);

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_A)     rd_data = DATA_W'(ctrl);
      else if (rd_addr == RES_A) rd_data = res_view;
   end

   // R7: frozen and not cleared, the value stays put
   assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.frz && !clr_pulse) |=> $stable(acc));
   // R4 / R5: a bit from the unselected direction changes nothing
   assert_wrong_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_valid && tap_dir != ctrl.dir_rx && !clr_pulse) |=> $stable(acc));
endmodule

// File: tb/sim_crc_tap_engine.sv
module sim_crc_tap_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        tap_bit = 1'b0, tap_valid = 1'b0, tap_dir = 1'b0;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   logic [1:0]  q_addr[$];
   logic [15:0] q_exp[$];
   string       q_tag[$];

   // bench model state
   logic [15:0] ref_acc = '0;
   logic        m_mode16 = 1'b0, m_rx = 1'b0, m_clr = 1'b1, m_frz = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   crc_tap_engine u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .tap_bit(tap_bit), .tap_valid(tap_valid), .tap_dir(tap_dir));

   function automatic logic [15:0] model_step(logic [15:0] a, logic b, logic m16);
      logic       fb;
      logic [6:0] n;
      if (m16) begin
         fb = b ^ a[15];
         return {a[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      fb = b ^ a[6];
      n  = {a[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      return {9'b0, n};
   endfunction

   function automatic logic [15:0] model_view();
      return m_mode16 ? ref_acc : (ref_acc & 16'h007F);
   endfunction

   // monitor: pops expected reads and compares
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q_exp.size() > 0) begin
            logic [15:0] e;
            string       t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            void'(q_addr.pop_front());
            checks++;
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
            end
         end
      end
   end

   task automatic expect_read(input logic [1:0] a, input logic [15:0] e, input string tag);
      @(negedge clk);
      rd_addr = a;
      q_addr.push_back(a);
      q_exp.push_back(e);
      q_tag.push_back(tag);
      @(posedge clk);
      #3;
   endtask

   task automatic write_ctrl(input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (d[2] && !m_clr) ref_acc = '0;
      m_mode16 = d[0]; m_rx = d[1]; m_clr = d[2]; m_frz = d[3];
   endtask

   task automatic send_byte(input logic [7:0] b, input logic dir);
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         tap_valid = 1'b1; tap_bit = b[i]; tap_dir = dir;
         if (dir == m_rx && !m_frz) ref_acc = model_step(ref_acc, b[i], m_mode16);
      end
      @(negedge clk);
      tap_valid = 1'b0;
   endtask

   task automatic send_check_string();
      for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k), m_rx);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_read(2'd0, 16'h0004, "R1 control after reset");
      expect_read(2'd1, 16'h0000, "R1 result after reset");

      // R2 check string, CRC16, transmit
      write_ctrl(16'h0001);
      write_ctrl(16'h0005);
      expect_read(2'd0, 16'h0005, "R10 control readback");
      send_check_string();
      expect_read(2'd1, 16'h31C3, "R2 check string 16-bit");
      expect_read(2'd1, model_view(), "R2 model agrees");

      // R4 received bits ignored while transmit selected
      held = model_view();
      for (int k = 0; k < 3; k++) send_byte(8'hA5 ^ 8'(k), 1'b1);
      expect_read(2'd1, held, "R4 receive bits ignored");

      // R9 strobe low
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         tap_bit = k[0]; tap_dir = k[1];
      end
      expect_read(2'd1, held, "R9 no strobe no change");

      // R6 clear sequence rules
      write_ctrl(16'h0005);
      expect_read(2'd1, held, "R6 repeated 1 does not clear");
      write_ctrl(16'h0001);
      expect_read(2'd1, held, "R6 write of 0 does not clear");
      write_ctrl(16'h0005);
      expect_read(2'd1, 16'h0000, "R6 0 then 1 clears");

      // R3 check string, CRC7
      write_ctrl(16'h0000);
      write_ctrl(16'h0004);
      send_check_string();
      expect_read(2'd1, 16'h0075, "R3 check string 7-bit");

      // R5 receive select with interleaved transmit noise, CRC16
      write_ctrl(16'h0003);
      write_ctrl(16'h0007);
      for (int k = 0; k < 24; k++) begin
         send_byte(8'($urandom), 1'b1);
         send_byte(8'($urandom), 1'b0);
      end
      expect_read(2'd1, model_view(), "R5 receive stream 16-bit");

      // R7 freeze
      held = model_view();
      write_ctrl(16'h000F);
      for (int k = 0; k < 4; k++) send_byte(8'($urandom), 1'b1);
      expect_read(2'd1, held, "R7 frozen value holds");
      expect_read(2'd0, 16'h000F, "R10 control with freeze");
      write_ctrl(16'h0007);
      for (int k = 0; k < 4; k++) send_byte(8'($urandom), 1'b1);
      expect_read(2'd1, model_view(), "R7 resumes after unfreeze");

      // R8 mode change keeps value
      held = ref_acc;
      write_ctrl(16'h0006);
      expect_read(2'd1, held & 16'h007F, "R8 mode switch keeps low bits");
      for (int k = 0; k < 6; k++) send_byte(8'($urandom), 1'b1);
      expect_read(2'd1, model_view(), "R8 narrow continues from low bits");

      // R2 / R3 random transmit streams in both modes
      for (int r = 0; r < 4; r++) begin
         logic [15:0] base;
         base = {15'b0, r[0]};
         write_ctrl(base);
         write_ctrl(base | 16'h0004);
         for (int k = 0; k < 32; k++) send_byte(8'($urandom), 1'b0);
         if (r[0]) expect_read(2'd1, model_view(), "R2 random stream 16-bit");
         else      expect_read(2'd1, model_view(), "R3 random stream 7-bit");
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule